// File: doc/BRIEF.md
# Dual-Channel Reference Divider with Halving Option

This block divides a reference clock, given as a per-cycle enable on the system clock, by a programmable 12-bit ratio. From it come two reference strobes, one for each of a pair of frequency-synthesizer channels. A single down-counter serves both channels. Channel A always runs at the input rate divided by the ratio. Channel B runs at that same rate, or at half of it when the halving select is high, through a divide-by-two stage that passes every second terminal count.

Each channel has its own run input. When a channel's run input is low, its strobe is held low, and for channel B the halving phase is also cleared. The counter keeps running, so the other channel keeps its timing. A new ratio is picked up only when the counter reloads, so a period that has already started is never shortened or stretched. Ratios below the legal minimum of 6 are raised to 6.

Top module: `refdiv_dual`

## Requirements
- R1: While `rst_n` is low, both strobes are low. Reset clears the counter to zero, so the first enabled tick after reset is a terminal count.
- R2: A terminal count occurs on an enabled tick that finds the counter at zero. `strobe_a` rises in the clock cycle after that tick and is high for exactly one clock cycle. Terminal counts are spaced exactly ratio enabled ticks apart.
- R3: Clock cycles with `clk_en` low do not advance the counter and produce no strobe.
- R4: With `half_sel` = 0 and both channels running, `strobe_b` is high in exactly the same cycles as `strobe_a`.
- R5: With `half_sel` = 1, `strobe_b` follows every second terminal count. The first terminal count after entering this mode, or after channel B starts running, passes.
- R6: A change of `ratio` takes effect only at the next terminal count. The period already under way keeps the length it was loaded with.
- R7: With `run_a` = 0, `strobe_a` stays low, and the counter and channel B are unaffected.
- R8: With `run_b` = 0, `strobe_b` stays low and the halving phase returns to its start state.
- R9: A `ratio` value from 0 to 5 divides by 6. Ratios from 6 to 4095 divide by their own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | One reference-clock tick per high cycle |
| ratio | input | 12 | Division ratio R |
| half_sel | input | 1 | 1: channel B divides by 2R |
| run_a | input | 1 | Channel A active (0 = power save) |
| run_b | input | 1 | Channel B active (0 = power save) |
| strobe_a | output | 1 | Channel A reference strobe |
| strobe_b | output | 1 | Channel B reference strobe |

## Verification
If the counter reloads with the wrong value, or reloads at the wrong moment, both strobes drift from the model at the next terminal count. That happens no more than one period (R enabled ticks) after the fault. If the halving phase is wrong, `strobe_b` lands on the alternate terminal count, which shows within two periods. The bench compares both strobes against a behavioural model on every clock. It does this across several ticking patterns, ratio changes made in the middle of a period, ratios below the minimum, the 4095 maximum, and each channel's run input switched on and off.

// File: rtl/refdiv_dual.sv
module refdiv_dual #(
  parameter int W         = 12,
  parameter int MIN_RATIO = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic [W-1:0] ratio,
  input  logic         half_sel,
  input  logic         run_a,
  input  logic         run_b,
  output logic         strobe_a,
  output logic         strobe_b
);
  localparam logic [W-1:0] FLOOR = W'(MIN_RATIO);

  logic [W-1:0] cnt_q;
  logic         skip_q;

  wire [W-1:0] eff = (ratio < FLOOR) ? FLOOR : ratio;
  wire         tc  = clk_en && (cnt_q == '0);
  wire         pass_b = run_b && (!half_sel || !skip_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clk_en) begin
      cnt_q <= (cnt_q == '0) ? eff - W'(1) : cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
    end else if (!run_b || !half_sel) begin
      skip_q <= 1'b0;
    end else if (tc) begin
      skip_q <= !skip_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_a <= 1'b0;
      strobe_b <= 1'b0;
    end else begin
      strobe_a <= tc && run_a;
      strobe_b <= tc && pass_b;
    end
  end

  assert_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_a |=> !strobe_a);

  assert_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clk_en) |-> (!strobe_a && !strobe_b));

  assert_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_b && $past(run_a)) |-> strobe_a);

  assert_idle_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_a) |-> !strobe_a);

  assert_idle_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_b) |-> !strobe_b);
endmodule

// File: tb/refdiv_dual_tb.sv
module refdiv_dual_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0;
  logic [11:0] ratio = 12'd10;
  logic        half_sel = 1'b0;
  logic        run_a = 1'b1;
  logic        run_b = 1'b1;
  logic        strobe_a, strobe_b;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  string cur_req = "R1";

  int   m_left = 0;
  bit   m_skip = 1'b0;
  bit   m_tc;
  int   m_eff;
  logic ea = 1'b0;
  logic eb = 1'b0;

  always #5 clk = ~clk;

  refdiv_dual u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ratio(ratio),
    .half_sel(half_sel), .run_a(run_a), .run_b(run_b),
    .strobe_a(strobe_a), .strobe_b(strobe_b)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_left = 0;
      m_skip = 1'b0;
      ea <= 1'b0;
      eb <= 1'b0;
    end else begin
      m_eff = (int'(ratio) < 6) ? 6 : int'(ratio);
      m_tc  = clk_en && (m_left == 0);
      if (clk_en) m_left = m_tc ? m_eff - 1 : m_left - 1;
      ea <= m_tc && run_a;
      eb <= m_tc && run_b && (!half_sel || !m_skip);
      if (!run_b || !half_sel) m_skip = 1'b0;
      else if (m_tc) m_skip = !m_skip;
    end
  end

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc >= 1) begin
      checks++;
      if (strobe_a !== ea) begin
        fails++;
        $display("FAIL %s strobe_a cycle %0d: got %b expected %b", cur_req, cyc, strobe_a, ea);
      end
      checks++;
      if (strobe_b !== eb) begin
        fails++;
        $display("FAIL %s strobe_b cycle %0d: got %b expected %b", cur_req, cyc, strobe_b, eb);
      end
    end
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      finish_up();
    end
  end

  task automatic run(input int n, input int en_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clk_en = (en_every <= 1) ? 1'b1 : ((i % en_every) == 0);
    end
  endtask

  initial begin
    cur_req = "R1";
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R2";
    run(120, 1);
    cur_req = "R3";
    run(300, 3);
    run(200, 2);
    cur_req = "R5";
    half_sel = 1'b1;
    run(400, 1);
    run(300, 4);
    cur_req = "R6";
    run(4, 1);
    ratio = 12'd7;
    run(200, 1);
    ratio = 12'd13;
    run(5, 1);
    ratio = 12'd9;
    run(200, 1);
    cur_req = "R4";
    half_sel = 1'b0;
    run(200, 1);
    cur_req = "R9";
    ratio = 12'd3;
    run(150, 1);
    ratio = 12'd0;
    run(150, 1);
    ratio = 12'd6;
    run(150, 1);
    cur_req = "R7";
    half_sel = 1'b1;
    run_a = 1'b0;
    run(200, 1);
    run_a = 1'b1;
    run(100, 1);
    cur_req = "R8";
    run(9, 1);
    run_b = 1'b0;
    run(50, 1);
    run_b = 1'b1;
    run(200, 1);
    run_b = 1'b0;
    run(3, 1);
    run_b = 1'b1;
    run(150, 2);
    cur_req = "R2";
    ratio = 12'd4095;
    half_sel = 1'b1;
    run(17000, 1);
    cur_req = "R1";
    rst_n = 1'b0;
    run(4, 1);
    rst_n = 1'b1;
    ratio = 12'd8;
    run(100, 1);
    finish_up();
  end
endmodule